// File: doc/BRIEF.md
# Longest-Prefix Route Lookup Cache

This block resolves an IPv4 destination address to a next-hop index by longest-prefix match. A small direct-mapped cache on chip holds the routes that lookups have used recently. The full route table lives in a larger backing memory, reached through a request/response port with variable latency. Each lookup comes with a bit vector from an upstream membership filter, one bit per prefix length from 0 to 32. The block tries only the flagged lengths, from the longest down. For each length it masks the address and probes the cache. On a cache miss it asks the backing memory. A found entry is installed into the cache with no software involved, and it becomes the answer. The first confirmed match therefore ends the search and is the longest one.

A control-plane port changes the routes. The control plane writes the backing table itself and sends the same change here, so the cached copy never goes stale. A delete drops a matching cached entry. An add or a modify rewrites the next hop in place when the entry is cached. Pending updates are served before any new lookup. The cache index is an XOR fold of the masked prefix and its length. A fill overwrites whatever the indexed slot held.

Top module: `lpm_route_cache`

## Requirements
- R1: After reset, resValid and memReqValid are 0, and lkReady and cpReady are 1 while cpValid is 0.
- R2: Bit L of lkBloom flags prefix length L (0 to 32). Only flagged lengths are tried, longest first. The result is the longest flagged length whose masked prefix exists in the route table, and resLen carries that length.
- R3: Every backing request carries a prefix length and a prefix whose bits below that length (the low 32-L address bits) are zero.
- R4: A cache miss on a probe raises memReqValid. The request holds its prefix and length stable until memReqReady accepts it. The response gives memRspFound and memRspNh.
- R5: A found response is written into the cache and returned. Repeating that lookup at once issues no backing request.
- R6: A not-found response is not cached. The search continues at the next shorter flagged length, and a repeat lookup asks the backing memory again.
- R7: When no flagged length matches, including an all-zero lkBloom, the result has resHit=0, resLen=0 and resNh=DEFAULT_NH (all ones by default). An all-zero lkBloom issues no request.
- R8: While cpValid is high in the idle state, lkReady is 0. An update offered in the same cycle as a lookup is applied before that lookup.
- R9: A delete (cpOp=1) of a cached route invalidates it. Later lookups never return the deleted next hop.
- R10: An add (cpOp=0) or a modify (cpOp=2) of a cached route replaces its next hop in place. The next lookup returns the new value with no backing request. An add of an uncached route leaves the cache unchanged.
- R11: cpOp=3 is accepted and has no effect on cached entries.
- R12: Each accepted lookup yields exactly one single-cycle resValid pulse. lkReady and cpReady stay 0 from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request valid |
| lkReady | output | 1 | Lookup request accepted when high with lkValid |
| lkAddr | input | 32 | Destination address |
| lkBloom | input | 33 | Flagged prefix lengths, bit L = length L |
| resValid | output | 1 | Result pulse |
| resHit | output | 1 | Result matched a route |
| resLen | output | 6 | Matched prefix length (0 on no match) |
| resNh | output | NH_W | Next-hop index or DEFAULT_NH |
| memReqValid | output | 1 | Backing memory request valid |
| memReqReady | input | 1 | Backing memory accepts request |
| memReqPrefix | output | 32 | Masked prefix requested |
| memReqLen | output | 6 | Prefix length requested |
| memRspValid | input | 1 | Backing memory response valid |
| memRspFound | input | 1 | Route exists in the table |
| memRspNh | input | NH_W | Next hop of the found route |
| cpValid | input | 1 | Control-plane update valid |
| cpReady | output | 1 | Update accepted when high with cpValid |
| cpOp | input | 2 | 0 add, 1 delete, 2 modify, 3 no operation |
| cpPrefix | input | 32 | Route prefix (masked internally) |
| cpLen | input | 6 | Route prefix length |
| cpNh | input | NH_W | New next hop for add or modify |

## Verification
A corrupted tag, valid bit or next hop shows on resNh or resLen in the very lookup that probes the bad slot. A stale entry after an update shows on the first lookup after that update. A wrongly cached negative, or a fill that never happened, shows only in how many backing requests the repeat lookup makes. The bench therefore counts requests per lookup and checks that count right after each fill. A wrong probe order or mask shows as a shorter match than the table holds, or as a request with nonzero low bits, within the same lookup.

// File: rtl/lpm_cache_pkg.sv
package lpm_cache_pkg;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 6;
  localparam int NUM_LEN = ADDR_W + 1;

  typedef enum logic [1:0] {
    CP_ADD = 2'd0,
    CP_DEL = 2'd1,
    CP_MOD = 2'd2,
    CP_NOP = 2'd3
  } cpOpE;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CP,
    S_PROBE,
    S_REQ,
    S_WAIT,
    S_DONE
  } seqStateE;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchLk;
    logic latchCp;
    logic applyCp;
    logic dropLen;
    logic fillEn;
    logic resCache;
    logic resMem;
    logic resMiss;
  } dpStrobeT;

  function automatic logic [ADDR_W-1:0] lenMask(input logic [LEN_W-1:0] len);
    if (len == '0) return '0;
    else if (len >= LEN_W'(ADDR_W)) return '1;
    else return ~({ADDR_W{1'b1}} >> len);
  endfunction
endpackage

// File: rtl/lpm_cache_dp.sv
module lpm_cache_dp
  import lpm_cache_pkg::*;
#(
  parameter int NH_W = 8,
  parameter int IDX_W = 6,
  parameter logic [NH_W-1:0] DEFAULT_NH = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobeT            stb,
  input  logic [ADDR_W-1:0]   lkAddr,
  input  logic [NUM_LEN-1:0]  lkBloom,
  input  logic [1:0]          cpOp,
  input  logic [ADDR_W-1:0]   cpPrefix,
  input  logic [LEN_W-1:0]    cpLen,
  input  logic [NH_W-1:0]     cpNh,
  input  logic [NH_W-1:0]     memRspNh,
  output logic                anyLeft,
  output logic                probeHit,
  output logic [ADDR_W-1:0]   probePrefix,
  output logic [LEN_W-1:0]    probeLen,
  output logic                resHit,
  output logic [LEN_W-1:0]    resLen,
  output logic [NH_W-1:0]     resNh
);
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] foldIdx(input logic [ADDR_W-1:0] p,
                                               input logic [LEN_W-1:0] l);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < ADDR_W; i++) h[i % IDX_W] ^= p[i];
    for (int j = 0; j < LEN_W; j++) h[j % IDX_W] ^= l[j];
    return h;
  endfunction

  logic [ADDR_W-1:0]  addrQ;
  logic [NUM_LEN-1:0] remMask;
  cpOpE               cpOpQ;
  logic [ADDR_W-1:0]  cpPrefixQ;
  logic [LEN_W-1:0]   cpLenQ;
  logic [NH_W-1:0]    cpNhQ;

  logic [DEPTH-1:0]   cValid;
  logic [ADDR_W-1:0]  cPfx [DEPTH];
  logic [LEN_W-1:0]   cLen [DEPTH];
  logic [NH_W-1:0]    cNh  [DEPTH];

  logic [IDX_W-1:0]   probeIdx;
  logic [IDX_W-1:0]   cpIdx;
  logic               cpHit;

  // lookup and update context registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      remMask   <= '0;
      cpOpQ     <= CP_NOP;
      cpPrefixQ <= '0;
      cpLenQ    <= '0;
      cpNhQ     <= '0;
    end else begin
      if (stb.latchLk) begin
        addrQ   <= lkAddr;
        remMask <= lkBloom;
      end else if (stb.dropLen) begin
        remMask[probeLen] <= 1'b0;
      end
      if (stb.latchCp) begin
        cpOpQ     <= cpOpE'(cpOp);
        cpPrefixQ <= cpPrefix & lenMask(cpLen);
        cpLenQ    <= cpLen;
        cpNhQ     <= cpNh;
      end
    end
  end

  // highest remaining flagged length
  always_comb begin
    probeLen = '0;
    for (int l = 0; l < NUM_LEN; l++)
      if (remMask[l]) probeLen = LEN_W'(l);
  end

  assign anyLeft     = |remMask;
  assign probePrefix = addrQ & lenMask(probeLen);
  assign probeIdx    = foldIdx(probePrefix, probeLen);
  assign probeHit    = cValid[probeIdx] && (cPfx[probeIdx] == probePrefix)
                       && (cLen[probeIdx] == probeLen);
  assign cpIdx       = foldIdx(cpPrefixQ, cpLenQ);
  assign cpHit       = cValid[cpIdx] && (cPfx[cpIdx] == cpPrefixQ)
                       && (cLen[cpIdx] == cpLenQ);

  // one slot of the direct-mapped cache per iteration
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic              slotV;
    logic [ADDR_W-1:0] slotPfx;
    logic [LEN_W-1:0]  slotLen;
    logic [NH_W-1:0]   slotNh;
    logic              fillHere;
    logic              cpHere;

    assign fillHere = stb.fillEn && (probeIdx == IDX_W'(e));
    assign cpHere   = stb.applyCp && cpHit && (cpIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotV   <= 1'b0;
        slotPfx <= '0;
        slotLen <= '0;
        slotNh  <= '0;
      end else if (fillHere) begin
        slotV   <= 1'b1;
        slotPfx <= probePrefix;
        slotLen <= probeLen;
        slotNh  <= memRspNh;
      end else if (cpHere) begin
        unique case (cpOpQ)
          CP_DEL:         slotV  <= 1'b0;
          CP_ADD, CP_MOD: slotNh <= cpNhQ;
          default:        ;
        endcase
      end
    end

    assign cValid[e] = slotV;
    assign cPfx[e]   = slotPfx;
    assign cLen[e]   = slotLen;
    assign cNh[e]    = slotNh;
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resHit <= 1'b0;
      resLen <= '0;
      resNh  <= DEFAULT_NH;
    end else if (stb.resCache) begin
      resHit <= 1'b1;
      resLen <= probeLen;
      resNh  <= cNh[probeIdx];
    end else if (stb.resMem) begin
      resHit <= 1'b1;
      resLen <= probeLen;
      resNh  <= memRspNh;
    end else if (stb.resMiss) begin
      resHit <= 1'b0;
      resLen <= '0;
      resNh  <= DEFAULT_NH;
    end
  end
endmodule

// File: rtl/lpm_cache_ctrl.sv
module lpm_cache_ctrl
  import lpm_cache_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lkValid,
  input  logic     cpValid,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     memRspFound,
  input  logic     anyLeft,
  input  logic     probeHit,
  output logic     lkReady,
  output logic     cpReady,
  output logic     memReqValid,
  output logic     resValid,
  output dpStrobeT stb
);
  seqStateE state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign cpReady     = (state == S_IDLE);
  assign lkReady     = (state == S_IDLE) && !cpValid;
  assign memReqValid = (state == S_REQ);
  assign resValid    = (state == S_DONE);

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      S_IDLE: begin
        if (cpValid) begin
          stb.latchCp = 1'b1;
          stateNext   = S_CP;
        end else if (lkValid) begin
          stb.latchLk = 1'b1;
          stateNext   = S_PROBE;
        end
      end
      S_CP: begin
        stb.applyCp = 1'b1;
        stateNext   = S_IDLE;
      end
      S_PROBE: begin
        if (!anyLeft) begin
          stb.resMiss = 1'b1;
          stateNext   = S_DONE;
        end else if (probeHit) begin
          stb.resCache = 1'b1;
          stateNext    = S_DONE;
        end else begin
          stateNext = S_REQ;
        end
      end
      S_REQ: begin
        if (memReqReady) stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (memRspValid) begin
          if (memRspFound) begin
            stb.fillEn = 1'b1;
            stb.resMem = 1'b1;
            stateNext  = S_DONE;
          end else begin
            stb.dropLen = 1'b1;
            stateNext   = S_PROBE;
          end
        end
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end
endmodule

// File: rtl/lpm_route_cache.sv
module lpm_route_cache
  import lpm_cache_pkg::*;
#(
  parameter int NH_W = 8,
  parameter int IDX_W = 6,
  parameter logic [NH_W-1:0] DEFAULT_NH = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lkValid,
  output logic                lkReady,
  input  logic [ADDR_W-1:0]   lkAddr,
  input  logic [NUM_LEN-1:0]  lkBloom,
  output logic                resValid,
  output logic                resHit,
  output logic [LEN_W-1:0]    resLen,
  output logic [NH_W-1:0]     resNh,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [ADDR_W-1:0]   memReqPrefix,
  output logic [LEN_W-1:0]    memReqLen,
  input  logic                memRspValid,
  input  logic                memRspFound,
  input  logic [NH_W-1:0]     memRspNh,
  input  logic                cpValid,
  output logic                cpReady,
  input  logic [1:0]          cpOp,
  input  logic [ADDR_W-1:0]   cpPrefix,
  input  logic [LEN_W-1:0]    cpLen,
  input  logic [NH_W-1:0]     cpNh
);
  dpStrobeT stb;
  logic     anyLeft;
  logic     probeHit;

  lpm_cache_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lkValid     (lkValid),
    .cpValid     (cpValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspFound (memRspFound),
    .anyLeft     (anyLeft),
    .probeHit    (probeHit),
    .lkReady     (lkReady),
    .cpReady     (cpReady),
    .memReqValid (memReqValid),
    .resValid    (resValid),
    .stb         (stb)
  );

  lpm_cache_dp #(
    .NH_W       (NH_W),
    .IDX_W      (IDX_W),
    .DEFAULT_NH (DEFAULT_NH)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .lkAddr      (lkAddr),
    .lkBloom     (lkBloom),
    .cpOp        (cpOp),
    .cpPrefix    (cpPrefix),
    .cpLen       (cpLen),
    .cpNh        (cpNh),
    .memRspNh    (memRspNh),
    .anyLeft     (anyLeft),
    .probeHit    (probeHit),
    .probePrefix (memReqPrefix),
    .probeLen    (memReqLen),
    .resHit      (resHit),
    .resLen      (resLen),
    .resNh       (resNh)
  );
endmodule

// File: rtl/lpm_cache_chk.sv
module lpm_cache_chk
  import lpm_cache_pkg::*;
#(
  parameter int NH_W = 8,
  parameter logic [NH_W-1:0] DEFAULT_NH = '1
) (
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic              lkReady,
  input logic              cpValid,
  input logic              cpReady,
  input logic              resValid,
  input logic              resHit,
  input logic [LEN_W-1:0]  resLen,
  input logic [NH_W-1:0]   resNh,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqPrefix,
  input logic [LEN_W-1:0]  memReqLen
);
  p_req_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqLen <= LEN_W'(ADDR_W))
                    && ((memReqPrefix & ~lenMask(memReqLen)) == '0));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqPrefix)
                                    && $stable(memReqLen));

  p_miss_default_r7: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resHit |-> (resNh == DEFAULT_NH) && (resLen == '0));

  p_update_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    cpValid && cpReady |-> !lkReady);

  p_res_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && lkReady |=> !lkReady && !cpReady);

  p_idle_no_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    lkReady |-> !memReqValid && !resValid);
endmodule

bind lpm_route_cache lpm_cache_chk #(
  .NH_W       (NH_W),
  .DEFAULT_NH (DEFAULT_NH)
) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .lkValid      (lkValid),
  .lkReady      (lkReady),
  .cpValid      (cpValid),
  .cpReady      (cpReady),
  .resValid     (resValid),
  .resHit       (resHit),
  .resLen       (resLen),
  .resNh        (resNh),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqPrefix (memReqPrefix),
  .memReqLen    (memReqLen)
);

// File: tb/test_lpm_route_cache.sv
module test_lpm_route_cache;
  localparam int NH = 8;
  localparam logic [NH-1:0] DEF_NH = 8'hFF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lkValid = 1'b0;
  logic          lkReady;
  logic [31:0]   lkAddr = '0;
  logic [32:0]   lkBloom = '0;
  logic          resValid, resHit;
  logic [5:0]    resLen;
  logic [NH-1:0] resNh;
  logic          memReqValid;
  logic          memReqReady = 1'b0;
  logic [31:0]   memReqPrefix;
  logic [5:0]    memReqLen;
  logic          memRspValid = 1'b0;
  logic          memRspFound = 1'b0;
  logic [NH-1:0] memRspNh = '0;
  logic          cpValid = 1'b0;
  logic          cpReady;
  logic [1:0]    cpOp = 2'd3;
  logic [31:0]   cpPrefix = '0;
  logic [5:0]    cpLen = '0;
  logic [NH-1:0] cpNh = '0;

  always #5 clk = ~clk;

  lpm_route_cache i_lpm_route_cache (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkReady(lkReady), .lkAddr(lkAddr), .lkBloom(lkBloom),
    .resValid(resValid), .resHit(resHit), .resLen(resLen), .resNh(resNh),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqPrefix(memReqPrefix), .memReqLen(memReqLen),
    .memRspValid(memRspValid), .memRspFound(memRspFound), .memRspNh(memRspNh),
    .cpValid(cpValid), .cpReady(cpReady), .cpOp(cpOp),
    .cpPrefix(cpPrefix), .cpLen(cpLen), .cpNh(cpNh)
  );

  typedef struct {
    logic          hit;
    logic [5:0]    len;
    logic [NH-1:0] nh;
    int            reqs;
    string         tag;
  } expT;

  expT           sbQ[$];
  logic [NH-1:0] routes [logic [37:0]];
  int            nChecks = 0;
  int            nFails = 0;
  int            reqSeen = 0;
  int            latCnt = 0;
  logic          prevRes = 1'b0;

  function automatic logic [31:0] ip(int a, int b, int c, int d);
    return {a[7:0], b[7:0], c[7:0], d[7:0]};
  endfunction

  function automatic logic [31:0] bMask(int len);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < len; i++) m[31-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [32:0] lens(int a, int b, int c);
    logic [32:0] v;
    v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  task automatic check(input logic ok, input string tag, input string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic setRoute(input logic [31:0] p, input int len, input logic [NH-1:0] nh);
    routes[{6'(len), p & bMask(len)}] = nh;
  endtask

  // driver: expected result from the route table, longest flagged length first
  task automatic doLookup(input logic [31:0] addr, input logic [32:0] bloom,
                          input int reqs, input string tag);
    expT e;
    e.hit = 1'b0; e.len = '0; e.nh = DEF_NH; e.reqs = reqs; e.tag = tag;
    for (int l = 32; l >= 0; l--) begin
      if (bloom[l] && routes.exists({6'(l), addr & bMask(l)})) begin
        e.hit = 1'b1; e.len = 6'(l); e.nh = routes[{6'(l), addr & bMask(l)}];
        break;
      end
    end
    sbQ.push_back(e);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = addr; lkBloom = bloom;
    while (!lkReady) @(negedge clk);
    @(negedge clk);
    lkValid = 1'b0;
    while (sbQ.size() != 0) @(negedge clk);
  endtask

  task automatic doUpdate(input logic [1:0] op, input logic [31:0] p, input int len,
                          input logic [NH-1:0] nh);
    @(negedge clk);
    cpValid = 1'b1; cpOp = op; cpPrefix = p; cpLen = 6'(len); cpNh = nh;
    while (!cpReady) @(negedge clk);
    @(negedge clk);
    cpValid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares each result pulse against the scoreboard head
  always @(negedge clk) begin
    if (rstN && resValid) begin
      check(!prevRes, "R12", "resValid high two cycles in a row");
      if (sbQ.size() == 0) begin
        check(1'b0, "R12", "result without a pending lookup");
      end else begin
        expT e;
        e = sbQ.pop_front();
        check(resHit == e.hit && resLen == e.len && resNh == e.nh
              && (e.reqs < 0 || reqSeen == e.reqs), e.tag,
              $sformatf("hit/len/nh/reqs act %0d/%0d/%0h/%0d exp %0d/%0d/%0h/%0d",
                        resHit, resLen, resNh, reqSeen, e.hit, e.len, e.nh, e.reqs));
      end
      reqSeen = 0;
    end
    prevRes = resValid;
  end

  // backing memory model with varying latency
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memReqValid) begin
        logic [31:0] p;
        int          l;
        repeat (latCnt % 3) @(negedge clk);
        p = memReqPrefix;
        l = int'(memReqLen);
        check(l <= 32 && (p & ~bMask(l)) == '0, "R3",
              $sformatf("request prefix %08h len %0d act, expected low bits zero", p, l));
        memReqReady = 1'b1;
        reqSeen++;
        @(negedge clk);
        memReqReady = 1'b0;
        repeat (1 + latCnt % 2) @(negedge clk);
        memRspValid = 1'b1;
        memRspFound = routes.exists({6'(l), p});
        memRspNh    = memRspFound ? routes[{6'(l), p}] : 8'h5A;
        @(negedge clk);
        memRspValid = 1'b0;
        latCnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    setRoute(ip(10,0,0,0), 8, 8'd1);
    setRoute(ip(10,1,0,0), 16, 8'd2);
    setRoute(ip(10,1,2,0), 24, 8'd3);
    setRoute(ip(192,168,0,0), 16, 8'd4);
    setRoute(ip(192,168,1,1), 32, 8'd12);
    setRoute(ip(0,0,0,0), 0, 8'd11);

    repeat (3) @(negedge clk);
    check(resValid == 1'b0, "R1", $sformatf("resValid act %0d exp 0", resValid));
    check(memReqValid == 1'b0, "R1", $sformatf("memReqValid act %0d exp 0", memReqValid));
    check(lkReady == 1'b1, "R1", $sformatf("lkReady act %0d exp 1", lkReady));
    check(cpReady == 1'b1, "R1", $sformatf("cpReady act %0d exp 1", cpReady));
    rstN = 1'b1;
    @(negedge clk);
    check(lkReady == 1'b1 && resValid == 1'b0, "R1", "idle after reset release");

    doLookup(ip(10,1,2,5), lens(24,16,8), 1, "R2 R4 first fetch of /24");
    doLookup(ip(10,1,2,5), lens(24,16,8), 0, "R5 repeat served from cache");
    doLookup(ip(10,1,9,9), lens(24,16,8), 2, "R6 negative /24 then /16");
    doLookup(ip(10,1,9,9), lens(24,16,8), 1, "R6 negative not cached");
    doLookup(ip(10,1,2,5), lens(8,-1,-1), 1, "R2 unflagged longer lengths skipped");
    doLookup(ip(172,16,0,1), lens(24,16,-1), 2, "R7 no match gives default");
    doLookup(ip(172,16,0,1), '0, 0, "R7 empty flag vector");
    doLookup(ip(172,16,0,1), lens(24,0,-1), 2, "R2 zero-length route");
    doLookup(ip(192,168,1,1), lens(32,16,-1), 1, "R2 host route length 32");

    doLookup(ip(10,1,2,5), lens(24,-1,-1), -1, "R10 warm /24");
    setRoute(ip(10,1,2,0), 24, 8'd9);
    doUpdate(2'd2, ip(10,1,2,0), 24, 8'd9);
    doLookup(ip(10,1,2,5), lens(24,-1,-1), 0, "R10 modify in place");

    routes.delete({6'd24, ip(10,1,2,0)});
    doUpdate(2'd1, ip(10,1,2,0), 24, 8'd0);
    doLookup(ip(10,1,2,5), lens(24,16,8), -1, "R9 delete not returned");
    doLookup(ip(10,1,2,5), lens(24,-1,-1), 1, "R9 deleted entry refetched");

    setRoute(ip(10,1,2,0), 24, 8'd7);
    doUpdate(2'd0, ip(10,1,2,0), 24, 8'd7);
    doLookup(ip(10,1,2,5), lens(24,-1,-1), 1, "R10 add of uncached route");
    doUpdate(2'd3, ip(10,1,2,0), 24, 8'd5);
    doLookup(ip(10,1,2,5), lens(24,-1,-1), 0, "R11 no-op update ignored");
    setRoute(ip(10,1,2,0), 24, 8'd6);
    doUpdate(2'd0, ip(10,1,2,0), 24, 8'd6);
    doLookup(ip(10,1,2,5), lens(24,-1,-1), 0, "R10 add of cached route");

    // R8: update and lookup offered together
    begin
      expT e;
      setRoute(ip(10,1,2,0), 24, 8'd13);
      e.hit = 1'b1; e.len = 6'd24; e.nh = 8'd13; e.reqs = 0; e.tag = "R8 update before lookup";
      sbQ.push_back(e);
      @(negedge clk);
      cpValid = 1'b1; cpOp = 2'd2; cpPrefix = ip(10,1,2,0); cpLen = 6'd24; cpNh = 8'd13;
      lkValid = 1'b1; lkAddr = ip(10,1,2,5); lkBloom = lens(24,-1,-1);
      #1;
      check(lkReady == 1'b0, "R8", $sformatf("lkReady act %0d exp 0", lkReady));
      @(negedge clk);
      cpValid = 1'b0;
      while (!lkReady) @(negedge clk);
      @(negedge clk);
      lkValid = 1'b0;
      while (sbQ.size() != 0) @(negedge clk);
    end

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule